// File: doc/BRIEF.md
# Protected Watchdog Timer

This block is a watchdog timer whose 16-bit up-counter, tick rate and enable can only be changed through a guarded two-step write sequence on its primary control port. Software first writes a password, which is the fixed key with the end-of-init bit cleared. The very next primary write is then a modify write, and it may set end-of-init. Settings placed in the request register are held as shadow values. They take effect only when a modify write sets end-of-init. That same modify write reloads the counter and clears the sticky error flags.

Two events are treated as faults: a wrongly ordered or wrongly keyed control write, and a counter wrap. Either one raises a sticky status flag and starts a prewarning phase. The prewarning phase runs for a fixed number of further ticks and then issues a single-cycle reset request. The status flags cannot be cleared while prewarning is active.

Top module: `protected_wdt`

## Requirements
- R1: After reset, all four status bits are 0, end_of_init is 0, count is 0, prewarn is 0 and rst_req is 0.
- R2: A valid access is a password write followed by a modify write. The password write carries the key KEY in ctl_wdata[KEY_W:1] and a 0 in ctl_wdata[0]. The modify write is the next ctl_wr, whatever it carries, and writes on the request port in between do not break the sequence. On the modify write, end_of_init takes the value of ctl_wdata[0].
- R3: A primary write that is neither a password write nor the modify write of a valid access sets status[0] (access error). This also happens while the timer is disabled.
- R4: When a tick advances count from all ones, count becomes 0 and status[1] (overflow error) is set.
- R5: status[0] and status[1] are sticky. They clear only on a modify write with ctl_wdata[0]=1 while prewarn is 0. While prewarn is 1, such a write leaves them set.
- R6: status[2] selects the tick rate: 0 means one tick every 2^SLOW_LOG2 clocks, and 1 means one tick every 2^FAST_LOG2 clocks. It is loaded from the requested rate, req_wdata[1], only on a modify write with ctl_wdata[0]=1.
- R7: status[3] is the disable flag and is loaded from req_wdata[0] under the same condition as status[2]. While status[3] is 1, count and the prescaler hold their values.
- R8: A modify write with ctl_wdata[0]=1 loads count from the requested reload value req_wdata[CNT_W+1:2] and clears the prescaler. It does this only if the newly committed disable flag is 0 and prewarn is 0.
- R9: An access error or an overflow sets prewarn. After PW_TICKS further ticks, rst_req is 1 for exactly one cycle and prewarn returns to 0.
- R10: A modify write with ctl_wdata[0]=0 commits neither rate nor disable, reloads nothing and leaves the error flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the primary control register |
| ctl_wdata | input | KEY_W+1 | Primary write data: key in [KEY_W:1], end-of-init in [0] |
| req_wr | input | 1 | Write strobe for the request register |
| req_wdata | input | CNT_W+2 | Reload value in [CNT_W+1:2], requested rate in [1], requested disable in [0] |
| status | output | 4 | Disable, rate, overflow error, access error (bits 3..0) |
| end_of_init | output | 1 | Current end-of-init bit |
| count | output | CNT_W | Watchdog counter value |
| prewarn | output | 1 | Prewarning phase active |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The bench keeps the 16-bit counter. It shrinks the slow divider to 16 clocks, the fast divider to 4 clocks and the prewarning length to 3 ticks. Together with a reload value just below the wrap point, this puts the counter wrap, the full prewarning phase and the reset pulse within a few dozen cycles. The settings also make both tick rates measurable by exact counter values. They make room for clear attempts inside prewarning and for error-flag checks while the timer is disabled.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef struct packed {
    logic dis;
    logic rate;
    logic ovf_err;
    logic acc_err;
  } wdt_status_t;

endpackage

// File: rtl/wdt_access.sv
module wdt_access #(
  parameter int KEY_W = 8,
  parameter logic [KEY_W-1:0] KEY = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ctl_wr,
  input  logic [KEY_W:0] ctl_wdata,
  output logic           end_of_init,
  output logic           acc_err_evt,
  output logic           commit
);

  logic armed_q, armed_d;
  logic eoi_q, eoi_d;
  logic pw_ok;

  assign pw_ok = (ctl_wdata[KEY_W:1] == KEY) && !ctl_wdata[0];

  always_comb begin
    armed_d     = armed_q;
    eoi_d       = eoi_q;
    acc_err_evt = 1'b0;
    commit      = 1'b0;
    if (ctl_wr) begin
      if (armed_q) begin
        armed_d = 1'b0;
        eoi_d   = ctl_wdata[0];
        commit  = ctl_wdata[0];
      end else if (pw_ok) begin
        armed_d = 1'b1;
      end else begin
        acc_err_evt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      eoi_q   <= 1'b0;
    end else if (ctl_wr) begin
      armed_q <= armed_d;
      eoi_q   <= eoi_d;
    end
  end

  assign end_of_init = eoi_q;

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int SLOW_LOG2 = 14,
  parameter int FAST_LOG2 = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  input  logic fast,
  output logic tick
);

  localparam logic [SLOW_LOG2-1:0] SLOW_MASK = '1;
  localparam logic [SLOW_LOG2-1:0] FAST_MASK = SLOW_MASK >> (SLOW_LOG2 - FAST_LOG2);

  logic [SLOW_LOG2-1:0] pre_q, pre_d;
  logic [SLOW_LOG2-1:0] mask;
  logic                 pre_en;

  assign mask   = fast ? FAST_MASK : SLOW_MASK;
  assign tick   = run && ((pre_q & mask) == mask);
  assign pre_en = clr || run;

  always_comb begin
    if (clr) pre_d = '0;
    else     pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W    = 16,
  parameter int PW_TICKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             err_in,
  output logic [CNT_W-1:0] count,
  output logic             ovf_evt,
  output logic             prewarn,
  output logic             rst_req
);

  localparam int PW_W = $clog2(PW_TICKS + 1);
  localparam logic [PW_W-1:0] PW_LAST = PW_W'(PW_TICKS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PW_W-1:0]  pw_q, pw_d;
  logic             pw_on_q, pw_on_d;
  logic             req_q, req_d;
  logic             last_tick, err_any;

  assign ovf_evt   = tick && !load && (cnt_q == '1);
  assign err_any   = err_in || ovf_evt;
  assign last_tick = pw_on_q && tick && (pw_q == PW_LAST);

  always_comb begin
    if (load)      cnt_d = load_val;
    else if (tick) cnt_d = cnt_q + 1'b1;
    else           cnt_d = cnt_q;

    if (!pw_on_q)  pw_d = '0;
    else if (tick) pw_d = pw_q + 1'b1;
    else           pw_d = pw_q;

    if (!pw_on_q && err_any) pw_on_d = 1'b1;
    else if (last_tick)      pw_on_d = 1'b0;
    else                     pw_on_d = pw_on_q;

    req_d = last_tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pw_q    <= '0;
      pw_on_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      if (load || tick) cnt_q <= cnt_d;
      pw_q    <= pw_d;
      pw_on_q <= pw_on_d;
      req_q   <= req_d;
    end
  end

  assign count   = cnt_q;
  assign prewarn = pw_on_q;
  assign rst_req = req_q;

endmodule

// File: rtl/protected_wdt.sv
module protected_wdt #(
  parameter int CNT_W     = 16,
  parameter int KEY_W     = 8,
  parameter logic [KEY_W-1:0] KEY = 8'hC3,
  parameter int SLOW_LOG2 = 14,
  parameter int FAST_LOG2 = 8,
  parameter int PW_TICKS  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [KEY_W:0]   ctl_wdata,
  input  logic             req_wr,
  input  logic [CNT_W+1:0] req_wdata,
  output logic [3:0]       status,
  output logic             end_of_init,
  output logic [CNT_W-1:0] count,
  output logic             prewarn,
  output logic             rst_req
);
  import wdt_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [CNT_W-1:0] rld_q;
  logic             rate_req_q, dis_req_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rld_q      <= '0;
      rate_req_q <= 1'b0;
      dis_req_q  <= 1'b0;
    end else if (req_wr) begin
      rld_q      <= req_wdata[CNT_W+1:2];
      rate_req_q <= req_wdata[1];
      dis_req_q  <= req_wdata[0];
    end
  end

  logic acc_evt, commit, ovf_evt, tick, load, pw_on;
  wdt_status_t st_q, st_d;

  wdt_access #(.KEY_W(KEY_W), .KEY(KEY)) u_access (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .ctl_wr     (ctl_wr),
    .ctl_wdata  (ctl_wdata),
    .end_of_init(end_of_init),
    .acc_err_evt(acc_evt),
    .commit     (commit)
  );

  assign load = commit && !dis_req_q && !pw_on;

  wdt_prescaler #(.SLOW_LOG2(SLOW_LOG2), .FAST_LOG2(FAST_LOG2)) u_pre (
    .clk  (clk),
    .rst_n(rst_int_n),
    .run  (!st_q.dis),
    .clr  (load),
    .fast (st_q.rate),
    .tick (tick)
  );

  wdt_counter #(.CNT_W(CNT_W), .PW_TICKS(PW_TICKS)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick    (tick),
    .load    (load),
    .load_val(rld_q),
    .err_in  (acc_evt),
    .count   (count),
    .ovf_evt (ovf_evt),
    .prewarn (pw_on),
    .rst_req (rst_req)
  );

  always_comb begin
    st_d = st_q;
    if (commit) begin
      st_d.rate = rate_req_q;
      st_d.dis  = dis_req_q;
    end
    if (acc_evt)              st_d.acc_err = 1'b1;
    else if (commit && !pw_on) st_d.acc_err = 1'b0;
    if (ovf_evt)              st_d.ovf_err = 1'b1;
    else if (commit && !pw_on) st_d.ovf_err = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) st_q <= '0;
    else            st_q <= st_d;
  end

  assign status  = st_q;
  assign prewarn = pw_on;

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_wr,
  input logic [3:0]       status,
  input logic             end_of_init,
  input logic [CNT_W-1:0] count,
  input logic             prewarn,
  input logic             rst_req
);

  a_r2_eoi_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctl_wr) |-> $stable(end_of_init));

  a_r5_no_clear_in_prewarn: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(prewarn) && $past(status[0])) |-> status[0]);

  a_r5_no_ovf_clear_in_prewarn: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(prewarn) && $past(status[1])) |-> status[1]);

  a_r6_settings_need_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctl_wr) |-> $stable(status[3:2]));

  a_r7_hold_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3] && $past(status[3])) |-> $stable(count));

  a_r9_err_enters_prewarn: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(status[0]) && !$past(prewarn)) |-> prewarn);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  a_r9_pulse_ends_prewarn: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> ($past(prewarn) && !prewarn));

endmodule

bind protected_wdt wdt_checker #(.CNT_W(CNT_W)) u_wdt_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_wr     (ctl_wr),
  .status     (status),
  .end_of_init(end_of_init),
  .count      (count),
  .prewarn    (prewarn),
  .rst_req    (rst_req)
);

// File: tb/protected_wdt_bench.sv
module protected_wdt_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int KEY_W = 8;
  localparam logic [KEY_W-1:0] KEY = 8'hC3;

  logic             clk, rst_n;
  logic             ctl_wr, req_wr;
  logic [KEY_W:0]   ctl_wdata;
  logic [CNT_W+1:0] req_wdata;
  logic [3:0]       status;
  logic             end_of_init, prewarn, rst_req;
  logic [CNT_W-1:0] count;

  int total = 0;
  int bad   = 0;
  int rq_cnt = 0;

  protected_wdt #(
    .CNT_W(CNT_W), .KEY_W(KEY_W), .KEY(KEY),
    .SLOW_LOG2(4), .FAST_LOG2(2), .PW_TICKS(3)
  ) u_protected_wdt (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .req_wr(req_wr), .req_wdata(req_wdata), .status(status),
    .end_of_init(end_of_init), .count(count), .prewarn(prewarn),
    .rst_req(rst_req)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (rst_req) rq_cnt++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [KEY_W-1:0] key, input logic eoi);
    ctl_wr = 1'b1; ctl_wdata = {key, eoi};
    @(negedge clk);
    ctl_wr = 1'b0; ctl_wdata = '0;
  endtask

  task automatic wr_req(input logic [CNT_W-1:0] rld, input logic rate, input logic dis);
    req_wr = 1'b1; req_wdata = {rld, rate, dis};
    @(negedge clk);
    req_wr = 1'b0; req_wdata = '0;
  endtask

  task automatic commit_eoi(input logic eoi);
    wr_ctl(KEY, 1'b0);
    wr_ctl(8'h00, eoi);
  endtask

  task automatic t_reset;
    check("R1 status", status, 4'h0);
    check("R1 eoi", end_of_init, 1'b0);
    check("R1 count", count, 16'h0);
    check("R1 prewarn", prewarn, 1'b0);
    check("R1 rst_req", rst_req, 1'b0);
  endtask

  task automatic t_commit_and_overflow;
    wr_req(16'hFFF0, 1'b1, 1'b0);
    commit_eoi(1'b1);
    check("R2 eoi set", end_of_init, 1'b1);
    check("R6 rate fast", status, 4'b0100);
    check("R8 reload", count, 16'hFFF0);
    repeat (16) @(negedge clk);
    check("R6 fast ticks", count, 16'hFFF4);
    rq_cnt = 0;
    repeat (48) @(negedge clk);
    check("R4 wrap", count, 16'h0000);
    check("R4 ovf flag", status[1], 1'b1);
    check("R9 prewarn on", prewarn, 1'b1);
    repeat (2) @(negedge clk);
    commit_eoi(1'b1);
    check("R5 ovf kept in prewarn", status[1], 1'b1);
    check("R8 no reload in prewarn", count, 16'h0001);
    repeat (12) @(negedge clk);
    check("R9 one pulse", rq_cnt, 1);
    check("R9 prewarn off", prewarn, 1'b0);
    commit_eoi(1'b1);
    check("R5 ovf cleared", status[1], 1'b0);
    check("R8 reload again", count, 16'hFFF0);
  endtask

  task automatic t_slow_rate;
    wr_req(16'hFFF0, 1'b0, 1'b0);
    commit_eoi(1'b1);
    check("R6 rate slow", status[2], 1'b0);
    repeat (32) @(negedge clk);
    check("R6 slow ticks", count, 16'hFFF2);
    wr_req(16'h1000, 1'b1, 1'b0);
    commit_eoi(1'b1);
    check("R6 rate back", status[2], 1'b1);
  endtask

  task automatic t_no_commit;
    wr_req(16'h2000, 1'b0, 1'b1);
    commit_eoi(1'b0);
    check("R10 eoi cleared", end_of_init, 1'b0);
    check("R10 status kept", status, 4'b0100);
    check("R10 no reload", (count != 16'h2000), 1'b1);
    wr_req(16'h1000, 1'b1, 1'b0);
    commit_eoi(1'b1);
    check("R10 eoi restored", end_of_init, 1'b1);
  endtask

  task automatic t_access_errors;
    rq_cnt = 0;
    wr_ctl(KEY ^ 8'h01, 1'b0);
    check("R3 wrong key", status[0], 1'b1);
    check("R9 prewarn from acc", prewarn, 1'b1);
    repeat (20) @(negedge clk);
    check("R9 acc pulse", rq_cnt, 1);
    commit_eoi(1'b1);
    check("R5 acc cleared", status[0], 1'b0);
    rq_cnt = 0;
    wr_ctl(KEY, 1'b1);
    check("R3 key with eoi", status[0], 1'b1);
    repeat (20) @(negedge clk);
    commit_eoi(1'b1);
    check("R5 acc cleared 2", status[0], 1'b0);
    wr_ctl(KEY, 1'b0);
    wr_req(16'h1000, 1'b1, 1'b0);
    wr_ctl(8'h00, 1'b1);
    check("R2 req write between", status[0], 1'b0);
    check("R2 reload after gap", count, 16'h1000);
  endtask

  task automatic t_disable;
    logic [CNT_W-1:0] held;
    wr_req(16'h1000, 1'b1, 1'b1);
    commit_eoi(1'b1);
    check("R7 dis set", status[3], 1'b1);
    held = count;
    repeat (40) @(negedge clk);
    check("R7 count held", count, held);
    rq_cnt = 0;
    wr_ctl(8'h00, 1'b1);
    check("R3 acc while disabled", status[0], 1'b1);
    repeat (40) @(negedge clk);
    check("R7 prewarn frozen", rq_cnt, 0);
    wr_req(16'h1000, 1'b1, 1'b0);
    commit_eoi(1'b1);
    check("R7 dis cleared", status[3], 1'b0);
    check("R5 acc kept", status[0], 1'b1);
    repeat (20) @(negedge clk);
    check("R9 pulse after enable", rq_cnt, 1);
    commit_eoi(1'b1);
    check("R5 acc cleared 3", status[0], 1'b0);
    check("R8 reload enabled", count, 16'h1000);
  endtask

  initial begin
    rst_n = 1'b0; ctl_wr = 1'b0; req_wr = 1'b0;
    ctl_wdata = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    fork
      begin
        t_reset();
        t_commit_and_overflow();
        t_slow_rate();
        t_no_commit();
        t_access_errors();
        t_disable();
      end
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule